// File: doc/BRIEF.md
# Bus Hold Handover Controller

This controller decides who drives a shared local bus: the processor's bus interface, or an external master such as a DMA engine. The external master asks for the bus by raising an asynchronous hold request. The controller first brings that request into the clock domain. It then lets any processor bus cycle that is already running finish. Only at that cycle boundary does it hand the bus over by raising a hold acknowledge. While the external master owns the bus, the processor may not start a new cycle, and every other bus output group is switched to high impedance.

When the hold request falls, the controller returns the bus in two steps. It drops the acknowledge first. One clock later it turns the processor's drivers back on, so the two masters never drive the bus at the same time. The processor's outgoing requests pass through a valid/ready channel. The controller holds that channel off while the bus is taken or about to be taken. A request that is waiting at that moment goes out unchanged once the bus comes back.

Back-pressure rules for the request channel: the requester holds `req_valid` and its payload steady until `req_ready` is high in the same cycle. The channel forwards the downstream ready only while the controller is not stalling. A transfer takes place on a clock edge where valid and ready are both high.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After reset, `hold_ack` is 0, every bit of `drv_oe` is 1 (drivers on) and `stall` is 0.
- R2: `hold_req` passes through a two-flop synchronizer. `stall` rises two clock edges after `hold_req` is first sampled high. `hold_ack` is still 0 at that point.
- R3: If no bus cycle is in progress, `hold_ack` rises on the clock edge right after the synchronized hold is seen. With the bus idle, that is the third edge after `hold_req` rises.
- R4: `hold_ack` never rises while a cycle is in progress (`cyc_busy` high and `cyc_done` low). When `cyc_done` is sampled high, it rises on that same edge.
- R5: Whenever `hold_ack` is 1, every bit of `drv_oe` is 0 (all non-acknowledge groups in high impedance).
- R6: While `stall` is 1, `bus_valid` and `req_ready` are both 0, so no new processor cycle can start. `stall` is 1 whenever `hold_ack` is 1.
- R7: After the synchronized hold falls, `hold_ack` goes to 0 on the next edge while `drv_oe` stays 0 for exactly that one cycle. On the following edge, `drv_oe` returns to all ones and `stall` drops.
- R8: When not stalling, the request channel passes straight through. `bus_valid`=`req_valid`, `req_ready`=`bus_ready`, and address, write data and write flag are copied unchanged. A request that waits through a grant comes out with the same payload after release.
- R9: A request accepted on the edge where the synchronized hold rises counts as a cycle in progress for the next cycle, even before `cyc_busy` rises. The grant waits for its `cyc_done`.
- R10: If the hold request is withdrawn while the controller is still waiting for a cycle to end, no acknowledge is issued. Control returns to the processor and `stall` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| cyc_busy | input | 1 | Bus interface has a cycle in progress |
| cyc_done | input | 1 | Last cycle of the current bus cycle |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Processor request accepted |
| req_addr | input | ADDR_W | Processor request address |
| req_wdata | input | DATA_W | Processor request write data |
| req_write | input | 1 | Processor request is a write |
| bus_valid | output | 1 | Request forwarded to bus interface |
| bus_ready | input | 1 | Bus interface can take a request |
| bus_addr | output | ADDR_W | Forwarded address |
| bus_wdata | output | DATA_W | Forwarded write data |
| bus_write | output | 1 | Forwarded write flag |
| hold_ack | output | 1 | Bus granted to external master |
| stall | output | 1 | Processor cycles blocked |
| drv_oe | output | N_OE | Output enable per bus pin group, 1 = drive |

## Verification
The assertions rely on three things about the bus interface. `cyc_done` is only high while `cyc_busy` is high. `cyc_busy` rises no later than the second edge after a request is accepted. No cycle is in progress while the bus is granted. The bench models the bus interface inside its scenario tasks, and it drives `cyc_busy` and `cyc_done` only in those legal patterns. In the late-start scenario it delays `cyc_busy` by the full one-cycle allowance. The request channel follows the hold-steady rule, with every input driven on falling edges.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    ST_OWN     = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_GRANT   = 2'd2,
    ST_RELEASE = 2'd3
  } own_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/req_gate.sv
module req_gate #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_write,
  output logic              launch_q
);
  logic xfer;

  // Pass-through channel, closed while stalled.
  assign bus_valid = req_valid & ~stall;
  assign req_ready = bus_ready & ~stall;
  assign bus_addr  = req_addr;
  assign bus_wdata = req_wdata;
  assign bus_write = req_write;
  assign xfer      = bus_valid & bus_ready;

  // Covers the gap before the bus interface raises its busy flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) launch_q <= 1'b0;
    else        launch_q <= xfer;
  end

  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!bus_valid && !req_ready));
endmodule

// File: rtl/handover_fsm.sv
module handover_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_s,
  input  logic cyc_busy,
  input  logic cyc_done,
  input  logic launch_q,
  output logic hold_ack,
  output logic stall,
  output logic drv_en_nxt
);
  own_state_e state_q, state_d;
  logic       in_flight;

  // A cycle counts as open if just launched or busy without its final beat.
  assign in_flight = launch_q | (cyc_busy & ~cyc_done);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN:     if (hold_s) state_d = in_flight ? ST_DRAIN : ST_GRANT;
      ST_DRAIN:   if (!hold_s)       state_d = ST_OWN;
                  else if (cyc_done) state_d = ST_GRANT;
      ST_GRANT:   if (!hold_s) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_OWN;
      default:    state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OWN;
      hold_ack <= 1'b0;
    end else begin
      state_q  <= state_d;
      hold_ack <= (state_d == ST_GRANT);
    end
  end

  assign stall      = hold_s | (state_q != ST_OWN);
  assign drv_en_nxt = (state_d == ST_OWN) || (state_d == ST_DRAIN);

  p_ack_needs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_s));
  p_no_mid_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(cyc_done || !cyc_busy));
  p_ack_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> stall);
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int N_OE        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req,
  input  logic              cyc_busy,
  input  logic              cyc_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_write,
  output logic              hold_ack,
  output logic              stall,
  output logic [N_OE-1:0]   drv_oe
);
  localparam logic [N_OE-1:0] OE_ALL = {N_OE{1'b1}};

  logic hold_s, launch_q, drv_en_nxt;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hold_req), .sync_out(hold_s)
  );

  handover_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .cyc_busy(cyc_busy),
    .cyc_done(cyc_done), .launch_q(launch_q), .hold_ack(hold_ack),
    .stall(stall), .drv_en_nxt(drv_en_nxt)
  );

  req_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_write(bus_write), .launch_q(launch_q)
  );

  // One enable flop per pin group keeps fanout local to each group.
  for (genvar g = 0; g < N_OE; g++) begin : g_oe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_oe[g] <= 1'b1;
      else        drv_oe[g] <= drv_en_nxt;
    end
  end

  p_ack_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (drv_oe == '0));
  p_gap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> (drv_oe == '0));
  p_gap_then_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |=> (drv_oe == OE_ALL));
endmodule

// File: tb/sim_bus_hold_ctrl.sv
module sim_bus_hold_ctrl;
  localparam int AW = 32, DW = 32, NO = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_req = 0, cyc_busy = 0, cyc_done = 0;
  logic req_valid = 0, req_write = 0, bus_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, bus_valid, bus_write, hold_ack, stall;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [NO-1:0] drv_oe;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_hold_ctrl #(.ADDR_W(AW), .DATA_W(DW), .N_OE(NO), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_busy(cyc_busy),
    .cyc_done(cyc_done), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_write(bus_write), .hold_ack(hold_ack),
    .stall(stall), .drv_oe(drv_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 hold_ack", hold_ack, 0);
    chk("R1 drv_oe", drv_oe, 4'hF);
    chk("R1 stall", stall, 0);
  endtask

  task automatic t_idle_grant;
    hold_req = 1;
    tick(1);
    chk("R2 stall after 1 edge", stall, 0);
    tick(1);
    chk("R2 stall after 2 edges", stall, 1);
    chk("R2 ack not yet", hold_ack, 0);
    tick(1);
    chk("R3 ack on 3rd edge", hold_ack, 1);
    chk("R5 drivers off", drv_oe, 4'h0);
    req_valid = 1; bus_ready = 1;
    #1;
    chk("R6 bus_valid blocked", bus_valid, 0);
    chk("R6 req_ready blocked", req_ready, 0);
    req_valid = 0; bus_ready = 0;
  endtask

  task automatic t_release;
    hold_req = 0;
    tick(2);
    chk("R7 ack held until sync", hold_ack, 1);
    tick(1);
    chk("R7 ack dropped", hold_ack, 0);
    chk("R7 drivers still off", drv_oe, 4'h0);
    chk("R7 stall in gap", stall, 1);
    tick(1);
    chk("R7 drivers back", drv_oe, 4'hF);
    chk("R7 stall released", stall, 0);
  endtask

  task automatic t_midcycle;
    cyc_busy = 1; hold_req = 1;
    tick(3);
    chk("R4 no ack mid-cycle", hold_ack, 0);
    chk("R4 stall while draining", stall, 1);
    tick(2);
    chk("R4 still no ack", hold_ack, 0);
    cyc_done = 1;
    tick(1);
    cyc_busy = 0; cyc_done = 0;
    chk("R4 ack at cycle end", hold_ack, 1);
    chk("R5 drivers off", drv_oe, 4'h0);
    t_release();
  endtask

  task automatic t_launch;
    hold_req = 1;
    tick(1);
    req_valid = 1; bus_ready = 1; req_addr = 32'h1000_0040;
    tick(1);
    req_valid = 0; bus_ready = 0;
    tick(1);
    chk("R9 launched cycle blocks grant", hold_ack, 0);
    cyc_busy = 1;
    tick(2);
    chk("R9 waiting for done", hold_ack, 0);
    cyc_done = 1;
    tick(1);
    cyc_busy = 0; cyc_done = 0;
    chk("R9 ack after done", hold_ack, 1);
    t_release();
  endtask

  task automatic t_pending;
    hold_req = 1;
    tick(3);
    chk("R8 grant", hold_ack, 1);
    req_valid = 1; bus_ready = 1;
    req_addr = 32'hDEAD_BEE0; req_wdata = 32'h1234_5678; req_write = 1;
    tick(1);
    chk("R8 held during grant", bus_valid, 0);
    hold_req = 0;
    tick(4);
    chk("R8 issued after release", bus_valid, 1);
    chk("R8 address unchanged", bus_addr, 32'hDEAD_BEE0);
    chk("R8 data unchanged", bus_wdata, 32'h1234_5678);
    chk("R8 write flag unchanged", bus_write, 1);
    chk("R8 ready passes", req_ready, 1);
    bus_ready = 0;
    #1;
    chk("R8 back-pressure passes", req_ready, 0);
    req_valid = 0; req_write = 0;
  endtask

  task automatic t_withdraw;
    cyc_busy = 1; hold_req = 1;
    tick(3);
    chk("R10 draining", stall, 1);
    hold_req = 0;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      chk("R10 no ack after withdraw", hold_ack, 0);
    end
    chk("R10 stall dropped", stall, 0);
    cyc_done = 1;
    tick(1);
    cyc_busy = 0; cyc_done = 0;
    chk("R10 still no ack", hold_ack, 0);
    chk("R10 drivers on", drv_oe, 4'hF);
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    t_reset();
    t_idle_grant();
    t_release();
    t_midcycle();
    t_launch();
    t_pending();
    t_withdraw();
    tick(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule